// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block runs one access on an external memory bus for a single chip-select region of a processor's local bus. It takes a request through a valid/ready handshake. It checks that the address falls in its region and then drives the chip select, the read strobe, four per-byte write strobes and a bus-start marker through a programmed sequence. The sequence has address setup, the strobe window with wait states, address hold, and an optional bus-start hold cycle. At the end the block gives a one-clock completion pulse.

Two bus styles are supported. In SRAM style the read strobe and the byte write strobes behave in the usual way. In card style the four write-strobe pins take new roles: register select, memory write enable, I/O read and I/O write. The read strobe then acts as the output enable. Card style uses its own setup and hold fields, chosen by whether the access is to memory or to I/O space, and it adds an encoded extra wait count to the base wait count.

Back-pressure: `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. From that edge until the cycle after the completion pulse, `req_ready` stays low. The requester keeps `req_valid` and the request fields steady until the request is taken. Configuration inputs are captured at the accepting edge. All strobes are active low.

Top module: `ebus_seq`

## Requirements
- R1: A request whose address bits [28:26] equal 3'b110 starts a bus cycle. The chip select and the bus-start marker go low in the first cycle after acceptance. A request with any other value in those bits is consumed, and no strobe and no completion pulse follow.
- R2: `req_ready` is high in reset and while idle. It is low from the accepting edge through the completion cycle, and it returns high in the following cycle.
- R3: In SRAM style the chip select is low for `cfg_setup` cycles (0 to 7) before the strobe window. It stays low for `cfg_hold` cycles (0 to 7) after the window, with all strobes high during those cycles.
- R4: The base wait count is `cfg_wait`, and values above 25 count as 25. The strobe window lasts at least the total wait count plus one cycle.
- R5: When the total wait count is nonzero, `ext_rdy` (active high) is sampled once per clock, starting in the last nominal strobe cycle. The window continues until a sample finds it high, and the strobes rise in the next cycle. When the total wait count is zero, `ext_rdy` has no effect.
- R6: The bus-start marker is low in the first cycle of the access. If `cfg_bshold` is set and the effective setup count is at least 1, one extra cycle follows the hold cycles, with chip select low, bus-start low and strobes high. Otherwise no such cycle occurs.
- R7: In card style (`cfg_pcmode`=1) the setup and hold counts range from 0 to 15. They come from the I/O fields when `req_io`=1 and from the memory fields when it is 0.
- R8: In card style the total wait count is the clamped base plus an extra count chosen by `cfg_pc_xwait`: 00 gives 0, 01 gives 15, 10 gives 30 and 11 gives 50.
- R9: In SRAM style a read drives `rd_n` low during the strobe window. A write drives `we_n[i]` low during the window for each `req_be[i]`=1. All strobes stay high whenever `cs_n` is high.
- R10: In card style the strobe pins are used as follows.
  - `we_n[0]` is low for the whole chip-select window on attribute or I/O accesses.
  - During the strobe window, `rd_n` is low for a memory read and `we_n[1]` is low for a memory write.
  - During the strobe window, `we_n[2]` is low for an I/O read and `we_n[3]` is low for an I/O write.
  - `req_io` takes precedence over `req_attr`.
- R11: `done` is high for exactly one cycle. That cycle directly follows the last chip-select cycle, and `cs_n` is high in it.
- R12: Configuration changes after the accepting edge do not alter the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 32 | Request address; bits [28:26] select the region |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte enables for SRAM-style writes |
| req_io | input | 1 | Card style: I/O space access |
| req_attr | input | 1 | Card style: attribute memory access |
| cfg_pcmode | input | 1 | 0 = SRAM style, 1 = card style |
| cfg_wait | input | 5 | Base wait count, clamped to 25 |
| cfg_setup | input | 3 | SRAM-style setup cycles |
| cfg_hold | input | 3 | SRAM-style hold cycles |
| cfg_bshold | input | 1 | Enable the bus-start hold cycle |
| cfg_pc_setup_mem | input | 4 | Card-style memory/attribute setup cycles |
| cfg_pc_hold_mem | input | 4 | Card-style memory/attribute hold cycles |
| cfg_pc_setup_io | input | 4 | Card-style I/O setup cycles |
| cfg_pc_hold_io | input | 4 | Card-style I/O hold cycles |
| cfg_pc_xwait | input | 2 | Card-style extra wait code |
| ext_rdy | input | 1 | External ready, active high |
| cs_n | output | 1 | Chip select |
| rd_n | output | 1 | Read strobe / output enable |
| we_n | output | 4 | Byte write strobes / card control strobes |
| bs_n | output | 1 | Bus-start marker |
| done | output | 1 | Access complete, one cycle |

## Verification
If the sequencer's counter or state goes wrong, the edges of the chip select or strobe window move. The strobes then start or end one or more cycles away from the count computed from the programmed fields and the ready pattern. The per-cycle comparison catches this in the first cycle that differs, usually during the same access. A wrongly latched request or mode shows as a wrong strobe pin within the first strobe cycle. A stuck state shows as `req_ready` failing to return in the cycle after `done`.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  localparam int CNT_W    = 7;
  localparam int SU_W     = 4;
  localparam int BASE_W   = 5;
  localparam int BE_W     = 4;
  localparam int MAX_BASE = 25;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD, ST_BSH, ST_DONE
  } ebus_st_e;

  typedef struct packed {
    logic [SU_W-1:0]  su;
    logic [SU_W-1:0]  hd;
    logic [CNT_W-1:0] wt;
    logic             bsh;
  } ebus_tm_t;

  typedef struct packed {
    logic            pc;
    logic            wr;
    logic            io;
    logic            attr;
    logic [BE_W-1:0] be;
  } ebus_rq_t;

  function automatic logic [CNT_W-1:0] pc_extra(input logic [1:0] code);
    case (code)
      2'b01:   return CNT_W'(15);
      2'b10:   return CNT_W'(30);
      2'b11:   return CNT_W'(50);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/ebus_timing.sv
module ebus_timing
  import ebus_pkg::*;
(
  input  logic              pcmode,
  input  logic              io,
  input  logic [BASE_W-1:0] base_wait,
  input  logic [2:0]        sram_su,
  input  logic [2:0]        sram_hd,
  input  logic              bshold,
  input  logic [SU_W-1:0]   pc_su_mem,
  input  logic [SU_W-1:0]   pc_hd_mem,
  input  logic [SU_W-1:0]   pc_su_io,
  input  logic [SU_W-1:0]   pc_hd_io,
  input  logic [1:0]        pc_xwait,
  output ebus_tm_t          tm
);
  logic [CNT_W-1:0] base_c;

  always_comb begin
    if (base_wait > BASE_W'(MAX_BASE)) base_c = CNT_W'(MAX_BASE);
    else                               base_c = CNT_W'(base_wait);
  end

  always_comb begin
    if (pcmode) begin
      tm.su = io ? pc_su_io : pc_su_mem;
      tm.hd = io ? pc_hd_io : pc_hd_mem;
      tm.wt = base_c + pc_extra(pc_xwait);
    end else begin
      tm.su = SU_W'(sram_su);
      tm.hd = SU_W'(sram_hd);
      tm.wt = base_c;
    end
    tm.bsh = bshold && (tm.su != '0);
  end
endmodule

// File: rtl/ebus_fsm.sv
module ebus_fsm
  import ebus_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  ebus_tm_t tm_in,
  input  ebus_rq_t rq_in,
  input  logic     rdy,
  output ebus_st_e st,
  output logic     first,
  output ebus_rq_t rq_q
);
  logic [CNT_W-1:0] cnt;
  logic [SU_W-1:0]  hd_q;
  logic [CNT_W-1:0] wt_q;
  logic             bsh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      hd_q  <= '0;
      wt_q  <= '0;
      bsh_q <= 1'b0;
      first <= 1'b0;
      rq_q  <= '0;
    end else begin
      first <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            rq_q  <= rq_in;
            hd_q  <= tm_in.hd;
            wt_q  <= tm_in.wt;
            bsh_q <= tm_in.bsh;
            first <= 1'b1;
            if (tm_in.su != '0) begin
              st  <= ST_SETUP;
              cnt <= CNT_W'(tm_in.su - SU_W'(1));
            end else begin
              st  <= ST_STROBE;
              cnt <= tm_in.wt;
            end
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            st  <= ST_STROBE;
            cnt <= wt_q;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_STROBE: begin
          if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else if (wt_q == '0 || rdy) begin
            if (hd_q != '0) begin
              st  <= ST_HOLD;
              cnt <= CNT_W'(hd_q - SU_W'(1));
            end else if (bsh_q) begin
              st <= ST_BSH;
            end else begin
              st <= ST_DONE;
            end
          end
        end
        ST_HOLD: begin
          if (cnt == '0) st <= bsh_q ? ST_BSH : ST_DONE;
          else           cnt <= cnt - CNT_W'(1);
        end
        ST_BSH:  st <= ST_DONE;
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ebus_drive.sv
module ebus_drive
  import ebus_pkg::*;
(
  input  ebus_st_e        st,
  input  logic            first,
  input  ebus_rq_t        rq,
  output logic            cs_n,
  output logic            rd_n,
  output logic [BE_W-1:0] we_n,
  output logic            bs_n,
  output logic            done
);
  logic in_cs, strb;
  logic [BE_W-1:0] sram_we, pc_we;

  assign in_cs = (st == ST_SETUP) || (st == ST_STROBE) ||
                 (st == ST_HOLD)  || (st == ST_BSH);
  assign strb  = (st == ST_STROBE);

  for (genvar i = 0; i < BE_W; i++) begin : g_byte
    assign sram_we[i] = strb && rq.wr && rq.be[i];
  end

  assign pc_we[0] = in_cs && (rq.io || rq.attr);
  assign pc_we[1] = strb && !rq.io && rq.wr;
  assign pc_we[2] = strb && rq.io && !rq.wr;
  assign pc_we[3] = strb && rq.io && rq.wr;

  always_comb begin
    cs_n = !in_cs;
    bs_n = !((first && in_cs) || (st == ST_BSH));
    done = (st == ST_DONE);
    if (rq.pc) begin
      rd_n = !(strb && !rq.io && !rq.wr);
      we_n = ~pc_we;
    end else begin
      rd_n = !(strb && !rq.wr);
      we_n = ~sram_we;
    end
  end
endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int         ADDR_W    = 32,
  parameter int         AREA_LSB  = 26,
  parameter logic [2:0] AREA_CODE = 3'b110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [BE_W-1:0]   req_be,
  input  logic              req_io,
  input  logic              req_attr,
  input  logic              cfg_pcmode,
  input  logic [BASE_W-1:0] cfg_wait,
  input  logic [2:0]        cfg_setup,
  input  logic [2:0]        cfg_hold,
  input  logic              cfg_bshold,
  input  logic [SU_W-1:0]   cfg_pc_setup_mem,
  input  logic [SU_W-1:0]   cfg_pc_hold_mem,
  input  logic [SU_W-1:0]   cfg_pc_setup_io,
  input  logic [SU_W-1:0]   cfg_pc_hold_io,
  input  logic [1:0]        cfg_pc_xwait,
  input  logic              ext_rdy,
  output logic              cs_n,
  output logic              rd_n,
  output logic [BE_W-1:0]   we_n,
  output logic              bs_n,
  output logic              done
);
  localparam int AREA_MSB = AREA_LSB + 2;

  ebus_st_e st;
  logic     first, hit, start;
  ebus_tm_t tm;
  ebus_rq_t rq_in, rq_q;
  logic     unused_addr;

  assign unused_addr = ^{req_addr[AREA_LSB-1:0], req_addr[ADDR_W-1:AREA_MSB+1]};
  assign hit       = (req_addr[AREA_MSB:AREA_LSB] == AREA_CODE);
  assign req_ready = (st == ST_IDLE);
  assign start     = req_valid && req_ready && hit;

  assign rq_in.pc   = cfg_pcmode;
  assign rq_in.wr   = req_write;
  assign rq_in.io   = req_io;
  assign rq_in.attr = req_attr;
  assign rq_in.be   = req_be;

  ebus_timing u_tm (
    .pcmode(cfg_pcmode), .io(req_io), .base_wait(cfg_wait),
    .sram_su(cfg_setup), .sram_hd(cfg_hold), .bshold(cfg_bshold),
    .pc_su_mem(cfg_pc_setup_mem), .pc_hd_mem(cfg_pc_hold_mem),
    .pc_su_io(cfg_pc_setup_io), .pc_hd_io(cfg_pc_hold_io),
    .pc_xwait(cfg_pc_xwait), .tm(tm)
  );

  ebus_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .tm_in(tm), .rq_in(rq_in),
    .rdy(ext_rdy), .st(st), .first(first), .rq_q(rq_q)
  );

  ebus_drive u_drv (
    .st(st), .first(first), .rq(rq_q), .cs_n(cs_n), .rd_n(rd_n),
    .we_n(we_n), .bs_n(bs_n), .done(done)
  );
endmodule

// File: rtl/ebus_seq_chk.sv
module ebus_seq_chk #(
  parameter logic [2:0] AREA_CODE = 3'b110
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [2:0] area_bits,
  input logic       cs_n,
  input logic       rd_n,
  input logic [3:0] we_n,
  input logic       bs_n,
  input logic       done
);
  assert_miss_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && area_bits != AREA_CODE) |=> (cs_n && !done));

  assert_hit_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && area_bits == AREA_CODE) |=> (!cs_n && !bs_n && !req_ready));

  assert_busy_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !req_ready);

  assert_strobe_in_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (rd_n && (&we_n)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  assert_done_cs_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && $past(!cs_n)));
endmodule

bind ebus_seq ebus_seq_chk #(.AREA_CODE(AREA_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .area_bits(req_addr[AREA_LSB+2:AREA_LSB]), .cs_n(cs_n), .rd_n(rd_n),
  .we_n(we_n), .bs_n(bs_n), .done(done)
);

// File: tb/sim_ebus_seq.sv
module sim_ebus_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] IDLE_V = 9'b1_1_1_1111_1_0;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n = 1'b0, req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic req_write = 0, req_io = 0, req_attr = 0;
  logic [3:0] req_be = '0;
  logic cfg_pcmode = 0, cfg_bshold = 0;
  logic [4:0] cfg_wait = '0;
  logic [2:0] cfg_setup = '0, cfg_hold = '0;
  logic [3:0] cfg_pc_setup_mem = '0, cfg_pc_hold_mem = '0, cfg_pc_setup_io = '0, cfg_pc_hold_io = '0;
  logic [1:0] cfg_pc_xwait = '0;
  logic ext_rdy = 1'b0;
  logic cs_n, rd_n, bs_n, done;
  logic [3:0] we_n;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  ebus_seq u0 (.*);

  function automatic logic [8:0] obs();
    return {req_ready, cs_n, rd_n, we_n, bs_n, done};
  endfunction

  task automatic chk(input logic [8:0] act, input logic [8:0] exp, input string tag, input int c);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d actual=%b expected=%b", tag, c, act, exp);
    end
  endtask

  // Behavioural model: expected pin pattern for each cycle after acceptance.
  task automatic run(input int T, input bit scr, input string tag);
    int base, su, hd, wt, bsh, ce, dc;
    bit pc, wr, io, at;
    logic [3:0] be;
    logic [4:0] s_wait; logic [2:0] s_su, s_hd;
    pc = cfg_pcmode; wr = req_write; io = req_io; at = req_attr; be = req_be;
    base = (cfg_wait > 25) ? 25 : int'(cfg_wait);
    if (pc) begin
      su = io ? int'(cfg_pc_setup_io) : int'(cfg_pc_setup_mem);
      hd = io ? int'(cfg_pc_hold_io) : int'(cfg_pc_hold_mem);
      case (cfg_pc_xwait)
        2'b00: wt = base;
        2'b01: wt = base + 15;
        2'b10: wt = base + 30;
        default: wt = base + 50;
      endcase
    end else begin
      su = int'(cfg_setup); hd = int'(cfg_hold); wt = base;
    end
    bsh = (cfg_bshold && su > 0) ? 1 : 0;
    ce = su + wt;
    if (wt > 0 && T > ce) ce = T;
    dc = ce + 1 + hd + bsh;
    s_wait = cfg_wait; s_su = cfg_setup; s_hd = cfg_hold;
    req_addr = 32'h1800_0040; req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c <= dc + 1; c++) begin
      bit cs, strb, bs, dn, rr, rd;
      logic [3:0] we;
      rr = (c == dc + 1);
      cs = (c < dc);
      strb = (c >= su) && (c <= ce);
      bs = cs && (c == 0 || (bsh == 1 && c == dc - 1));
      dn = (c == dc);
      if (pc) begin
        rd = strb && !io && !wr;
        we = {strb && io && wr, strb && io && !wr, strb && !io && wr, cs && (io || at)};
      end else begin
        rd = strb && !wr;
        we = (strb && wr) ? be : 4'b0000;
      end
      ext_rdy = (c >= T);
      if (scr) begin cfg_wait = 5'(c * 7); cfg_setup = 3'(c + 3); cfg_hold = 3'(~c); end
      chk(obs(), {rr, ~cs, ~rd, ~we, ~bs, dn}, tag, c);
      @(negedge clk);
    end
    cfg_wait = s_wait; cfg_setup = s_su; cfg_hold = s_hd;
  endtask

  task automatic sram(input bit w, input logic [3:0] b, input int wa, input int s, input int h, input bit bh);
    cfg_pcmode = 0; req_write = w; req_be = b; req_io = 0; req_attr = 0;
    cfg_wait = 5'(wa); cfg_setup = 3'(s); cfg_hold = 3'(h); cfg_bshold = bh;
  endtask

  task automatic card(input bit w, input bit i, input bit a, input int wa, input logic [1:0] xw);
    cfg_pcmode = 1; req_write = w; req_io = i; req_attr = a; req_be = 4'hF;
    cfg_wait = 5'(wa); cfg_pc_xwait = xw; cfg_bshold = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(obs(), IDLE_V, "R2 reset", 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(obs(), IDLE_V, "R2 idle", 0);

    sram(0, 4'hF, 0, 0, 0, 0); run(0, 0, "R9 read minimal");
    sram(1, 4'b0101, 2, 3, 2, 0); run(0, 0, "R3 R9 write setup/hold");
    sram(1, 4'b1010, 0, 7, 7, 0); run(0, 0, "R3 max setup/hold");
    sram(0, 4'hF, 3, 1, 1, 0); run(10, 0, "R5 ready stretch");
    sram(0, 4'hF, 0, 2, 1, 0); run(100, 0, "R5 ready ignored wait=0");
    sram(1, 4'hF, 31, 0, 0, 0); run(0, 0, "R4 wait clamp");
    sram(0, 4'hF, 1, 2, 1, 1); run(0, 0, "R6 bs hold");
    sram(0, 4'hF, 1, 0, 2, 1); run(0, 0, "R6 bs hold blocked");

    cfg_pc_setup_mem = 4'd5; cfg_pc_hold_mem = 4'd4; cfg_pc_setup_io = 4'd12; cfg_pc_hold_io = 4'd15;
    card(0, 0, 1, 2, 2'b01); run(0, 0, "R7 R8 R10 attr read");
    card(1, 1, 0, 0, 2'b11); run(0, 0, "R7 R8 R10 io write");
    card(1, 0, 0, 25, 2'b10); run(0, 0, "R8 R10 mem write");
    card(0, 1, 1, 1, 2'b00); run(9, 0, "R10 io read stretch");

    sram(1, 4'b0011, 4, 2, 3, 0); run(0, 1, "R12 config latched");

    req_addr = 32'h1400_0000; req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk(obs(), IDLE_V, "R1 miss ignored", k);
      @(negedge clk);
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule